// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This block is a compact processor core for a fixed 16-bit teaching instruction set. It holds eight 16-bit general registers, a word-addressed program counter and a three-flag condition register that records whether the last result was negative, zero or positive. Instructions and data share one synchronous memory port with a one-cycle read latency. Each instruction is fetched, decoded and then executed over one or more cycles. The indirect forms access memory twice.

The core covers arithmetic and logic with register or short immediate operands, bitwise complement, loads and stores in three addressing modes, address generation, conditional branches, register jumps and a small set of service calls. One service call sends a character to an output strobe, one takes a character through a ready/valid handshake, and one stops the core. An undefined opcode or an unknown service number also stops the core and raises a fault flag.

Top module: `mc16_core`

## Requirements
- R1: After reset the core issues an instruction read at parameter RESET_PC (default 0x3000), with halted and fault low. The condition flags reset to zero (N,Z,P = 0,1,0) and the registers reset to 0x0000.
- R2: Opcode 0001 adds and opcode 0101 ANDs R[ir[8:6]] with a second operand, writing R[ir[11:9]]. The second operand is R[ir[2:0]] when ir[5]=0, or ir[4:0] sign-extended to 16 bits when ir[5]=1.
- R3: Opcode 1001 writes the bitwise complement of R[ir[8:6]] into R[ir[11:9]].
- R4: Only opcodes 0001, 0101, 1001, 0010, 0110, 1010 and 1110 update the flags, from the value written: N when bit 15 is set, Z when the value is zero, P otherwise. Exactly one flag is set at all times, and stores, branches, jumps and service calls leave the flags unchanged.
- R5: Opcode 0000 branches to PC+1+sext(ir[8:0]) when the mask ir[11:9] (N,Z,P from bit 11 down) shares a set bit with the flags. Otherwise execution continues at PC+1.
- R6: Opcodes 0010 (load), 0011 (store R[ir[11:9]]) and 1110 (write the address into R[ir[11:9]] without a memory access) address PC+1+sext(ir[8:0]).
- R7: Opcodes 0110 (load) and 0111 (store R[ir[11:9]]) address R[ir[8:6]]+sext(ir[5:0]).
- R8: Opcodes 1010 and 1011 read the word at PC+1+sext(ir[8:0]) and use it as the final address. 1010 loads from that address into R[ir[11:9]]; 1011 stores R[ir[11:9]] there.
- R9: Opcode 1100 sets the PC to R[ir[8:6]].
- R10: Opcode 1111 with ir[7:0]=0x21 pulses the output strobe for exactly one cycle, carrying the low CHAR_W bits of R0.
- R11: Opcode 1111 with ir[7:0]=0x23 raises the input ready signal and waits until input valid is seen. It then loads the input byte, zero-extended, into R0.
- R12: Opcode 1111 with ir[7:0]=0x25 sets halted with fault low. After that the core stays halted and makes no memory access and no output strobe.
- R13: Opcodes 0100, 1000 and 1101, or opcode 1111 with any other vector, set fault and halted together.
- R14: The memory port never reads and writes in the same cycle. Read data is taken one cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address of the current access |
| mem_re | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_re |
| tx_data | output | CHAR_W | Character sent by the output service |
| tx_valid | output | 1 | One-cycle strobe qualifying tx_data |
| rx_data | input | CHAR_W | Character offered to the input service |
| rx_valid | input | 1 | rx_data is valid |
| rx_ready | output | 1 | The core is waiting for a character |
| halted | output | 1 | The core has stopped |
| fault | output | 1 | The core stopped on an illegal instruction or vector |

## Verification
Some properties are checked in every cycle by the assertions. The memory port never reads and writes at once. A halted core stays quiet and a fault always comes with a halt. The output strobe lasts one cycle. The flags hold exactly one set bit and do not change across stores, branches, jumps and service calls. The core makes no access while it waits for input. The values computed by arithmetic, the effective addresses, the branch choices and the double access of the indirect forms can only be seen in the bench's programs. There a scoreboard compares every store and every character against the values predicted from the requirements.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
   localparam int WORD_W   = 16;
   localparam int RIDX_W   = 3;
   localparam int NUM_REGS = 1 << RIDX_W;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [RIDX_W-1:0] ridx_t;

   typedef enum logic [3:0] {
      OP_BR   = 4'b0000, OP_ADD = 4'b0001, OP_LD  = 4'b0010, OP_ST   = 4'b0011,
      OP_X4   = 4'b0100, OP_AND = 4'b0101, OP_LDR = 4'b0110, OP_STR  = 4'b0111,
      OP_X8   = 4'b1000, OP_NOT = 4'b1001, OP_LDI = 4'b1010, OP_STI  = 4'b1011,
      OP_JMP  = 4'b1100, OP_RSV = 4'b1101, OP_LEA = 4'b1110, OP_TRAP = 4'b1111
   } op_e;

   typedef enum logic [2:0] {
      PH_FETCH, PH_DECODE, PH_EXEC, PH_IND, PH_LOAD, PH_KEYIN, PH_STOP
   } phase_e;

   localparam logic [7:0] SVC_PUTC = 8'h21;
   localparam logic [7:0] SVC_GETC = 8'h23;
   localparam logic [7:0] SVC_STOP = 8'h25;

   // Sign-extend the low 'bits' bits of raw to a full word.
   function automatic word_t sext(input word_t raw, input int bits);
      return word_t'($signed(raw << (WORD_W - bits)) >>> (WORD_W - bits));
   endfunction
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile
   import mc16_pkg::*;
#(
   parameter bit CLEAR_ON_RESET = 1'b1
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  ridx_t wr_idx,
   input  word_t wr_val,
   input  ridx_t rd_a_idx,
   output word_t rd_a_val,
   input  ridx_t rd_b_idx,
   output word_t rd_b_val
);
   word_t bank [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      word_t q;
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (wr_en && wr_idx == RIDX_W'(g))    q <= wr_val;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en && wr_idx == RIDX_W'(g))         q <= wr_val;
         end
      end
      assign bank[g] = q;
   end

   assign rd_a_val = bank[rd_a_idx];
   assign rd_b_val = bank[rd_b_idx];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
(
   input  op_e         opc,
   input  logic [5:0]  lo_bits,
   input  word_t       opnd_a,
   input  word_t       opnd_b,
   output word_t       result
);
   word_t second;

   assign second = lo_bits[5] ? sext(word_t'(lo_bits[4:0]), 5) : opnd_b;

   always_comb begin
      unique case (opc)
         OP_ADD:  result = opnd_a + second;
         OP_AND:  result = opnd_a & second;
         OP_NOT:  result = ~opnd_a;
         default: result = opnd_a;
      endcase
   end
endmodule

// File: rtl/mc16_flags.sv
module mc16_flags
   import mc16_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  word_t      value,
   output logic [2:0] nzp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     nzp <= 3'b010;
      else if (load)  nzp <= value[WORD_W-1] ? 3'b100 : (value == '0) ? 3'b010 : 3'b001;
   end

   // R4: exactly one flag is set at any time
   a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(nzp) == 1);
endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter logic [15:0] RESET_PC   = 16'h3000,
   parameter int          CHAR_W     = 8,
   parameter bit          CLEAR_REGS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [15:0]       mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   output logic [CHAR_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic              halted,
   output logic              fault
);
   if (CHAR_W < 1 || CHAR_W > WORD_W) begin : g_bad_char_w
      $error("mc16_core: CHAR_W must lie between 1 and the word width");
   end

   phase_e     ph, ph_n;
   word_t      pc, pc_n, ir;
   logic       fault_q, fault_set;
   op_e        opc;
   word_t      ra, rb, alu_y, pc_rel, base_rel;
   ridx_t      rb_idx;
   logic       rf_we, cc_ld;
   ridx_t      rf_wa;
   word_t      rf_wd;
   logic [2:0] cc;

   assign opc      = op_e'(ir[15:12]);
   assign pc_rel   = pc + sext(ir, 9);
   assign base_rel = ra + sext(ir, 6);
   assign rb_idx   = (opc == OP_ADD || opc == OP_AND) ? ir[2:0] : ir[11:9];

   mc16_regfile #(.CLEAR_ON_RESET(CLEAR_REGS)) u_rf (
      .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_idx(rf_wa), .wr_val(rf_wd),
      .rd_a_idx(ir[8:6]), .rd_a_val(ra), .rd_b_idx(rb_idx), .rd_b_val(rb));

   mc16_alu u_alu (.opc(opc), .lo_bits(ir[5:0]), .opnd_a(ra), .opnd_b(rb), .result(alu_y));

   mc16_flags u_cc (.clk(clk), .rst_n(rst_n), .load(cc_ld), .value(rf_wd), .nzp(cc));

   always_comb begin
      ph_n      = ph;
      pc_n      = pc;
      mem_addr  = pc;
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = rb;
      rf_we     = 1'b0;
      rf_wa     = ir[11:9];
      rf_wd     = alu_y;
      cc_ld     = 1'b0;
      tx_valid  = 1'b0;
      rx_ready  = 1'b0;
      fault_set = 1'b0;
      unique case (ph)
         PH_FETCH: begin
            mem_re = 1'b1;
            pc_n   = pc + 16'd1;
            ph_n   = PH_DECODE;
         end
         PH_DECODE: ph_n = PH_EXEC;
         PH_EXEC: begin
            ph_n = PH_FETCH;
            unique case (opc)
               OP_ADD, OP_AND, OP_NOT: begin rf_we = 1'b1; cc_ld = 1'b1; end
               OP_LEA: begin rf_we = 1'b1; rf_wd = pc_rel; cc_ld = 1'b1; end
               OP_BR:  if (|(ir[11:9] & cc)) pc_n = pc_rel;
               OP_JMP: pc_n = ra;
               OP_LD:  begin mem_addr = pc_rel;   mem_re = 1'b1; ph_n = PH_LOAD; end
               OP_LDR: begin mem_addr = base_rel; mem_re = 1'b1; ph_n = PH_LOAD; end
               OP_LDI, OP_STI: begin mem_addr = pc_rel; mem_re = 1'b1; ph_n = PH_IND; end
               OP_ST:  begin mem_addr = pc_rel;   mem_we = 1'b1; end
               OP_STR: begin mem_addr = base_rel; mem_we = 1'b1; end
               OP_TRAP: begin
                  if (ir[7:0] == SVC_PUTC)      tx_valid = 1'b1;
                  else if (ir[7:0] == SVC_GETC) ph_n = PH_KEYIN;
                  else if (ir[7:0] == SVC_STOP) ph_n = PH_STOP;
                  else begin fault_set = 1'b1; ph_n = PH_STOP; end
               end
               default: begin fault_set = 1'b1; ph_n = PH_STOP; end
            endcase
         end
         PH_IND: begin
            mem_addr = mem_rdata;
            if (opc == OP_LDI) begin mem_re = 1'b1; ph_n = PH_LOAD; end
            else begin mem_we = 1'b1; ph_n = PH_FETCH; end
         end
         PH_LOAD: begin
            rf_we = 1'b1;
            rf_wd = mem_rdata;
            cc_ld = 1'b1;
            ph_n  = PH_FETCH;
         end
         PH_KEYIN: begin
            rx_ready = 1'b1;
            rf_wa    = '0;
            rf_wd    = word_t'(rx_data);
            if (rx_valid) begin rf_we = 1'b1; ph_n = PH_FETCH; end
         end
         PH_STOP: ph_n = PH_STOP;
         default: ph_n = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_FETCH;
         pc      <= RESET_PC;
         ir      <= '0;
         fault_q <= 1'b0;
      end else begin
         ph <= ph_n;
         pc <= pc_n;
         if (ph == PH_DECODE) ir <= mem_rdata;
         if (fault_set)       fault_q <= 1'b1;
      end
   end

   assign tx_data = rb[CHAR_W-1:0];
   assign halted  = (ph == PH_STOP);
   assign fault   = fault_q;

   // R14: a single access per cycle on the shared port
   a_r14_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));
   // R12: a stopped core is silent and stays stopped
   a_r12_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_re && !mem_we && !tx_valid));
   a_r12_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   // R13: a fault always comes with a halt
   a_r13_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> halted);
   // R10: the output strobe lasts one cycle
   a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
   // R11: no memory traffic while waiting for a character
   a_r11_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (!mem_re && !mem_we));
   // R4: non-updating instructions keep the flags
   a_r4_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_EXEC && opc inside {OP_ST, OP_STR, OP_BR, OP_JMP, OP_TRAP}) |=> $stable(cc));
endmodule

// File: tb/sim_mc16_core.sv
`timescale 1ns/1ps
module sim_mc16_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_re, mem_we;
   logic [7:0]  tx_data, rx_data;
   logic        tx_valid, rx_valid, rx_ready, halted, fault;

   int n_cmp = 0;
   int n_bad = 0;

   logic [15:0] mem [4096];
   logic [7:0]  in_byte = 8'h00;

   typedef struct {
      bit          chr;
      logic [15:0] a;
      logic [15:0] d;
   } item_t;
   item_t sb[$];
   string tagq[$];

   always #5 clk = ~clk;

   mc16_core u0 (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .halted(halted), .fault(fault));

   // Memory model: one-cycle read latency, 4K words aliased by the low 12 address bits
   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
   end

   // Character source: answer a ready request after three waiting cycles
   initial begin
      int wait_cnt;
      wait_cnt = 0;
      rx_valid = 1'b0;
      rx_data  = 8'h00;
      forever begin
         @(negedge clk);
         if (rx_ready) begin
            wait_cnt++;
            if (wait_cnt == 3) begin rx_valid = 1'b1; rx_data = in_byte; end
            else rx_valid = 1'b0;
         end else begin
            rx_valid = 1'b0;
            wait_cnt = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
      end
   endtask

   task automatic push_wr(input logic [15:0] a, input logic [15:0] d, input string req);
      sb.push_back('{chr: 1'b0, a: a, d: d});
      tagq.push_back(req);
   endtask

   task automatic push_chr(input logic [7:0] c, input string req);
      sb.push_back('{chr: 1'b1, a: 16'h0, d: {8'h00, c}});
      tagq.push_back(req);
   endtask

   // Monitor: every store and every character is popped and compared
   always @(negedge clk) begin
      if (rst_n && (mem_we || tx_valid)) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R12", "unexpected port event", mem_we ? mem_addr : {8'h00, tx_data}, 16'hFFFF);
         end else begin
            item_t e;
            string t;
            e = sb.pop_front();
            t = tagq.pop_front();
            if (e.chr) begin
               chk(tx_valid && !mem_we, t, "character", {8'h00, tx_data}, e.d);
               chk({8'h00, tx_data} == e.d, t, "character value", {8'h00, tx_data}, e.d);
            end else begin
               chk(mem_we && mem_addr == e.a, t, "store address", mem_addr, e.a);
               chk(mem_wdata == e.d, t, "store data", mem_wdata, e.d);
            end
         end
      end
   end

   // Instruction encoders
   function automatic logic [15:0] e_alu_i(input logic [3:0] op, input logic [2:0] d,
                                           input logic [2:0] s, input logic [4:0] imm);
      return {op, d, s, 1'b1, imm};
   endfunction
   function automatic logic [15:0] e_alu_r(input logic [3:0] op, input logic [2:0] d,
                                           input logic [2:0] s1, input logic [2:0] s2);
      return {op, d, s1, 3'b000, s2};
   endfunction
   function automatic logic [15:0] e_not(input logic [2:0] d, input logic [2:0] s);
      return {4'b1001, d, s, 6'h3F};
   endfunction
   function automatic logic [15:0] e_pcr(input logic [3:0] op, input logic [2:0] r,
                                         input logic [8:0] off);
      return {op, r, off};
   endfunction
   function automatic logic [15:0] e_bo(input logic [3:0] op, input logic [2:0] r,
                                        input logic [2:0] b, input logic [5:0] off);
      return {op, r, b, off};
   endfunction
   function automatic logic [15:0] e_jmp(input logic [2:0] b);
      return {4'b1100, 3'b000, b, 6'h00};
   endfunction
   function automatic logic [15:0] e_trap(input logic [7:0] v);
      return {4'b1111, 4'h0, v};
   endfunction

   task automatic put(input logic [15:0] a, input logic [15:0] w);
      mem[a[11:0]] = w;
   endtask

   task automatic run(input bit exp_fault, input string req);
      bit done;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(mem_re && mem_addr == 16'h3000, "R1", "first fetch address", mem_addr, 16'h3000);
      chk(!halted && !fault, "R1", "halted/fault after reset", {14'h0, halted, fault}, 16'h0);
      done = 1'b0;
      for (int i = 0; i < 3000 && !done; i++) begin
         @(negedge clk);
         #1;
         if (halted) done = 1'b1;
      end
      repeat (8) @(negedge clk);
      #1;
      chk(halted, req, "halted", {15'h0, halted}, 16'h1);
      chk(fault == exp_fault, req, "fault", {15'h0, fault}, {15'h0, exp_fault});
      chk(sb.size() == 0, req, "events left unseen", 16'(sb.size()), 16'h0);
      sb.delete();
      tagq.delete();
   endtask

   initial begin
      #1500000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected halt");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
      mem_rdata = 16'h0000;

      // Scenario A: main program
      put(16'h3000, e_alu_i(4'b0001, 3'd1, 3'd0, 5'h09));     // R1 = 9
      put(16'h3001, e_alu_i(4'b0001, 3'd2, 3'd0, 5'h15));     // R2 = -11
      put(16'h3002, e_alu_r(4'b0001, 3'd3, 3'd1, 3'd2));      // R3 = 0xFFFE
      put(16'h3003, e_alu_i(4'b0101, 3'd4, 3'd3, 5'h07));     // R4 = 6
      put(16'h3004, e_alu_r(4'b0101, 3'd5, 3'd1, 3'd3));      // R5 = 8
      put(16'h3005, e_not(3'd6, 3'd5));                       // R6 = 0xFFF7
      put(16'h3006, e_pcr(4'b0011, 3'd3, 9'h039));            // ST -> 0x3040
      put(16'h3007, e_pcr(4'b0011, 3'd4, 9'h039));            // ST -> 0x3041
      put(16'h3008, e_pcr(4'b0011, 3'd5, 9'h039));            // ST -> 0x3042
      put(16'h3009, e_pcr(4'b0011, 3'd6, 9'h039));            // ST -> 0x3043
      put(16'h300A, e_pcr(4'b1110, 3'd7, 9'h045));            // R7 = 0x3050
      put(16'h300B, e_bo(4'b0111, 3'd1, 3'd7, 6'h3E));        // STR -> 0x304E
      put(16'h300C, e_pcr(4'b0010, 3'd0, 9'h053));            // R0 = M[0x3060], N
      put(16'h300D, e_pcr(4'b0000, 3'b010, 9'h001));          // BRz, not taken
      put(16'h300E, e_bo(4'b0111, 3'd0, 3'd7, 6'h00));        // STR -> 0x3050
      put(16'h300F, e_pcr(4'b1010, 3'd2, 9'h051));            // R2 = M[M[0x3061]], Z
      put(16'h3010, e_pcr(4'b0000, 3'b010, 9'h001));          // BRz, taken
      put(16'h3011, e_bo(4'b0111, 3'd1, 3'd7, 6'h01));        // skipped
      put(16'h3012, e_pcr(4'b1011, 3'd1, 9'h04F));            // STI via 0x3062
      put(16'h3013, e_pcr(4'b0000, 3'b010, 9'h001));          // BRz, taken (flags kept)
      put(16'h3014, e_bo(4'b0111, 3'd6, 3'd7, 6'h02));        // skipped
      put(16'h3015, e_pcr(4'b0000, 3'b101, 9'h001));          // BRnp, not taken
      put(16'h3016, e_bo(4'b0111, 3'd4, 3'd7, 6'h03));        // STR -> 0x3053
      put(16'h3017, e_bo(4'b0110, 3'd3, 3'd7, 6'h10));        // LDR R3 <- M[0x3060]
      put(16'h3018, e_bo(4'b0111, 3'd3, 3'd7, 6'h04));        // STR -> 0x3054
      put(16'h3019, e_pcr(4'b1110, 3'd5, 9'h006));            // R5 = 0x3020
      put(16'h301A, e_jmp(3'd5));
      for (int a = 16'h301B; a < 16'h3020; a++) put(16'(a), e_bo(4'b0111, 3'd1, 3'd7, 6'h05));
      put(16'h3020, e_trap(8'h23));                           // R0 = input
      put(16'h3021, e_trap(8'h21));
      put(16'h3022, e_alu_i(4'b0001, 3'd0, 3'd0, 5'h01));
      put(16'h3023, e_trap(8'h21));
      put(16'h3024, e_bo(4'b0111, 3'd0, 3'd7, 6'h06));        // STR -> 0x3056
      put(16'h3025, e_trap(8'h25));
      put(16'h3060, 16'h8001);
      put(16'h3061, 16'h3070);
      put(16'h3070, 16'h0000);
      put(16'h3062, 16'h3080);
      in_byte = 8'hC5;

      push_wr(16'h3040, 16'hFFFE, "R2");   // register add with negative immediate
      push_wr(16'h3041, 16'h0006, "R2");   // AND with immediate
      push_wr(16'h3042, 16'h0008, "R2");   // AND with register
      push_wr(16'h3043, 16'hFFF7, "R3");
      push_wr(16'h304E, 16'h0009, "R7");
      push_wr(16'h3050, 16'h8001, "R5");   // LD set N, BRz fell through
      push_wr(16'h3080, 16'h0009, "R8");   // STI through pointer
      push_wr(16'h3053, 16'h0006, "R4");   // stores kept Z, BRnp fell through
      push_wr(16'h3054, 16'h8001, "R7");   // LDR base+offset
      push_chr(8'hC5, "R11");
      push_chr(8'hC6, "R10");
      push_wr(16'h3056, 16'h00C6, "R9");   // JMP skipped the filler stores
      run(1'b0, "R12");

      // Scenario B: reserved opcode
      put(16'h3000, 16'hD000);
      run(1'b1, "R13");

      // Scenario C: unknown service number
      put(16'h3000, e_trap(8'h30));
      run(1'b1, "R13");

      // Scenario D: flags reset to Z, so BRz skips a faulting call
      put(16'h3000, e_pcr(4'b0000, 3'b010, 9'h001));
      put(16'h3001, e_trap(8'h30));
      put(16'h3002, e_trap(8'h25));
      run(1'b0, "R1");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule